// File: doc/BRIEF.md
# Fixed-Map Bank Controller with Cycle Interrupt

This block is the control logic of a small cartridge memory controller. It watches CPU writes in the upper half of the address space and produces bank numbers for the program memory windows, the 8 KiB character bank, a mirroring select and an interrupt request. In its default state it presents a fixed layout of 8 KiB program banks with a single switchable window. The window's bank is chosen by a 3-bit register.

A second register, the layout register, can replace the fixed layout with one 32 KiB block or with a 16 KiB block shown twice. The same register also picks the character bank and the mirroring. Its value is taken from the low eight bits of the write address, not from the data bus. This register is writable only when the variant select input carries the configured variant code.

An interrupt timer counts CPU-cycle ticks once it has been armed. When the count reaches its limit, the timer raises an interrupt and stops. The interrupt stays raised until software acknowledges it.

Top module: `fixed_map_banker`

## Requirements
- R1: After the power reset (`rst_n` low at a clock edge), the outputs are as follows: `prg_6000`=6, `prg_8000`=4, `prg_a000`=5, `prg_c000`=0 and `prg_e000`=7; `chr_bank`=0, `mirror_horiz`=0 and `irq`=0. The timer is disarmed and its count is 0.
- R2: A write with address 0x8000-0x9FFF does three things: it disarms the timer, sets the count to 0 and drops `irq`, all from the next cycle. If a tick arrives in the same cycle, the write takes precedence.
- R3: A write with address 0xA000-0xBFFF arms the timer. The count is not changed.
- R4: While the timer is armed, each cycle with `cpu_tick` high adds one to the count. The tick that would make the count `CNT_LIMIT` (4096) does three things instead: it sets `irq` from the next cycle, returns the count to 0 and disarms the timer. `irq` then stays high through any number of cycles and ticks, until an R2 write.
- R5: A write with address 0xE000-0xFFFF stores `cpu_data[2:0]` as the switchable bank. Data bits 7:3 have no effect.
- R6: A write with address 0xC000-0xDFFF loads `cpu_addr[7:0]` into the layout register, but only when `sub_sel` equals `VARIANT_ID` (1). `cpu_data` is ignored. When `sub_sel` has any other value, the write changes nothing.
- R7: When layout bit 3 is 0, the program banks are `prg_8000`=4, `prg_a000`=5, `prg_c000`=the switchable bank and `prg_e000`=7.
- R8: When layout bits 3 and 4 are both 1, let B = 2 OR layout[7:6]. The four windows from 0x8000 to 0xE000 then get the 8 KiB banks 4B, 4B+1, 4B+2 and 4B+3, in that order.
- R9: When layout bit 3 is 1 and bit 4 is 0, let B = 4 OR layout[7:5]. Windows 0x8000 and 0xC000 then get bank 2B, and windows 0xA000 and 0xE000 get bank 2B+1.
- R10: `chr_bank` equals layout[7:1]. `mirror_horiz` equals layout[0], where 1 means horizontal mirroring and 0 means vertical.
- R11: `warm_rst` high at a clock edge clears the layout register, and it takes precedence over a layout write in the same cycle. It leaves the switchable bank, the timer state and `irq` unchanged.
- R12: `prg_6000` is 6 in every layout.
- R13: Writes with `cpu_addr` below 0x8000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power reset |
| warm_rst | input | 1 | Synchronous warm reset; clears the layout register only |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| sub_sel | input | SUB_SEL_W | Board variant code |
| prg_6000 | output | 4 | 8 KiB bank at 0x6000 |
| prg_8000 | output | 4 | 8 KiB bank at 0x8000 |
| prg_a000 | output | 4 | 8 KiB bank at 0xA000 |
| prg_c000 | output | 4 | 8 KiB bank at 0xC000 |
| prg_e000 | output | 4 | 8 KiB bank at 0xE000 |
| chr_bank | output | 7 | 8 KiB character bank |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest state to reach from the ports is the terminal tick of the timer. It takes 4096 armed ticks, and it can interact with an acknowledge, a re-arm or a warm reset that lands near it. The stimulus drives uninterrupted tick runs, and it checks that `irq` is still low one tick before the limit and high one cycle after the limit. It also uses gapped tick patterns and acknowledges that cut a count short, and it checks that further ticks neither re-fire nor clear the held interrupt. A behavioural model advances alongside the design, so every cycle of these long runs is compared, not only their end points.

// File: rtl/fmb_pkg.sv
// Package fmb_pkg
// Shared types for the fixed-map bank controller.
// Assumes an 8-bit layout register and 8 KiB program bank numbers of four bits.
package fmb_pkg;

    localparam int LAYOUT_W = 8;
    localparam int PRG8_W   = 4;
    localparam int SEL_W    = 3;
    localparam int CHR_W    = LAYOUT_W - 1;
    localparam int SLOTS    = 4;

    // Register targeted by a CPU write.
    typedef enum logic [2:0] {
        WR_NONE,
        WR_ACK,
        WR_ARM,
        WR_LAYOUT,
        WR_BANK
    } wr_kind_e;

    // Program layout chosen by the layout register.
    typedef enum logic [1:0] {
        LAY_FIXED,
        LAY_BLOCK32,
        LAY_BLOCK16
    } prg_layout_e;

endpackage

// File: rtl/fmb_wr_decode.sv
// Module fmb_wr_decode
// Classifies one CPU write by its address into the register it targets.
// Assumes cpu_wr is a single-cycle strobe. A write to the layout register
// counts only when sub_sel matches VARIANT_ID; otherwise it becomes WR_NONE.
module fmb_wr_decode
    import fmb_pkg::*;
#(
    parameter int SUB_SEL_W  = 4,
    parameter int VARIANT_ID = 1
) (
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic [SUB_SEL_W-1:0] sub_sel,
    output wr_kind_e             wr_kind
);

    localparam logic [SUB_SEL_W-1:0] VID = SUB_SEL_W'(VARIANT_ID);

    logic variant_hit;
    assign variant_hit = (sub_sel == VID);

    // Map the 8 KiB address quarter above 0x8000 onto a write kind.
    always_comb begin
        wr_kind = WR_NONE;
        if (cpu_wr && cpu_addr[15]) begin
            unique case (cpu_addr[14:13])
                2'b00: wr_kind = WR_ACK;
                2'b01: wr_kind = WR_ARM;
                2'b10: wr_kind = variant_hit ? WR_LAYOUT : WR_NONE;
                2'b11: wr_kind = WR_BANK;
                default: wr_kind = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fmb_regs.sv
// Module fmb_regs
// Holds the layout register (loaded from the write address) and the 3-bit
// switchable bank register (loaded from the write data).
// Assumes the decode has already applied the variant gate. warm_rst clears
// only the layout register and takes precedence over a layout write.
module fmb_regs
    import fmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                warm_rst,
    input  wr_kind_e            wr_kind,
    input  logic [LAYOUT_W-1:0] addr_lo,
    input  logic [SEL_W-1:0]    data_lo,
    output logic [LAYOUT_W-1:0] layout_q,
    output logic [SEL_W-1:0]    bank_q
);

    // Layout register: cleared by either reset, loaded from the address.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_rst) begin
            layout_q <= '0;
        end else if (wr_kind == WR_LAYOUT) begin
            layout_q <= addr_lo;
        end
    end

    // Switchable bank register: cleared by the power reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr_kind == WR_BANK) begin
            bank_q <= data_lo;
        end
    end

    // R5: the bank register is left alone by any other kind of write.
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind != WR_BANK) |=> $stable(bank_q));

endmodule

// File: rtl/fmb_irq_timer.sv
// Module fmb_irq_timer
// Cycle-tick counter that raises a held interrupt after CNT_LIMIT armed ticks.
// Assumes that ack and arm never arrive together, since they come from
// different address ranges. On its terminal tick the counter returns to 0
// and disarms itself. ack clears the count, the arm state and irq, and it
// takes precedence over a tick in the same cycle.
module fmb_irq_timer #(
    parameter int CNT_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    input  logic arm,
    output logic irq
);

    localparam int CNT_W = (CNT_LIMIT > 1) ? $clog2(CNT_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CNT_LIMIT - 1);

    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             terminal;

    assign terminal = en_q && tick && (cnt_q == LAST);

    // Arm state, count and interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (ack) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (terminal) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            irq_q <= 1'b1;
        end else begin
            if (arm) begin
                en_q <= 1'b1;
            end
            if (en_q && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign irq = irq_q;

    // R2: an acknowledge leaves the timer idle and quiet.
    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!irq_q && !en_q && cnt_q == '0));

    // R3: arming takes effect unless the same cycle was the terminal tick.
    assert_arm_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (en_q || irq_q));

    // R4: the interrupt is held until it is acknowledged.
    assert_irq_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> irq_q);

    // R4: the interrupt rises only after an armed tick.
    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(en_q) && $past(tick)));

    // R4: the counter never runs while disarmed.
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ack) |=> $stable(cnt_q));

endmodule

// File: rtl/fmb_bank_map.sv
// Module fmb_bank_map
// Combinational mapping from the layout and switchable bank registers to the
// 8 KiB program banks, the character bank and the mirroring select.
// Assumes four 8 KiB windows from 0x8000, numbered 0 to 3, plus a window at
// 0x6000 that always holds bank 6.
module fmb_bank_map
    import fmb_pkg::*;
(
    input  logic [LAYOUT_W-1:0]          layout_q,
    input  logic [SEL_W-1:0]             bank_q,
    output logic [PRG8_W-1:0]            prg_low,
    output logic [SLOTS-1:0][PRG8_W-1:0] prg_slot,
    output logic [CHR_W-1:0]             chr_bank,
    output logic                         mirror_horiz
);

    localparam logic [PRG8_W-1:0] LOW_BANK = PRG8_W'(6);

    prg_layout_e layout;
    logic [1:0]  blk32;
    logic [2:0]  blk16;

    // Choose the layout from bits 3 and 4 of the layout register.
    always_comb begin
        if (!layout_q[3]) begin
            layout = LAY_FIXED;
        end else if (layout_q[4]) begin
            layout = LAY_BLOCK32;
        end else begin
            layout = LAY_BLOCK16;
        end
    end

    assign blk32 = 2'b10  | layout_q[7:6];
    assign blk16 = 3'b100 | layout_q[7:5];

    // Bank of one window in the fixed layout.
    function automatic logic [PRG8_W-1:0] fixed_bank(input int slot,
                                                     input logic [SEL_W-1:0] sel);
        case (slot)
            0:       fixed_bank = PRG8_W'(4);
            1:       fixed_bank = PRG8_W'(5);
            2:       fixed_bank = PRG8_W'(sel);
            default: fixed_bank = PRG8_W'(7);
        endcase
    endfunction

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [1:0] SIDX  = 2'(s);
        localparam logic       SHALF = SIDX[0];
        // Pick the bank of window s according to the active layout.
        assign prg_slot[s] = (layout == LAY_BLOCK32) ? {blk32, SIDX}  :
                             (layout == LAY_BLOCK16) ? {blk16, SHALF} :
                                                       fixed_bank(s, bank_q);
    end

    assign prg_low      = LOW_BANK;
    assign chr_bank     = layout_q[LAYOUT_W-1:1];
    assign mirror_horiz = layout_q[0];

endmodule

// File: rtl/fixed_map_banker.sv
// Module fixed_map_banker
// Top of the fixed-map bank controller: write decode, register file,
// cycle interrupt timer and bank mapping.
// Assumes one write strobe per CPU write and one tick per CPU cycle. Resets
// are synchronous: rst_n is the power reset and warm_rst is the warm reset.
module fixed_map_banker #(
    parameter int CNT_LIMIT  = 4096,
    parameter int SUB_SEL_W  = 4,
    parameter int VARIANT_ID = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 warm_rst,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_wr,
    input  logic                 cpu_tick,
    input  logic [SUB_SEL_W-1:0] sub_sel,
    output logic [3:0]           prg_6000,
    output logic [3:0]           prg_8000,
    output logic [3:0]           prg_a000,
    output logic [3:0]           prg_c000,
    output logic [3:0]           prg_e000,
    output logic [6:0]           chr_bank,
    output logic                 mirror_horiz,
    output logic                 irq
);
    import fmb_pkg::*;

    localparam logic [SUB_SEL_W-1:0] VID = SUB_SEL_W'(VARIANT_ID);

    wr_kind_e                     wr_kind;
    logic [LAYOUT_W-1:0]          layout_q;
    logic [SEL_W-1:0]             bank_q;
    logic [SLOTS-1:0][PRG8_W-1:0] prg_slot;
    logic                         unused_bits;

    assign unused_bits = ^{cpu_data[7:SEL_W], cpu_addr[12:LAYOUT_W]};

    fmb_wr_decode #(
        .SUB_SEL_W (SUB_SEL_W),
        .VARIANT_ID(VARIANT_ID)
    ) i_decode (
        .cpu_addr(cpu_addr),
        .cpu_wr  (cpu_wr),
        .sub_sel (sub_sel),
        .wr_kind (wr_kind)
    );

    fmb_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .wr_kind (wr_kind),
        .addr_lo (cpu_addr[LAYOUT_W-1:0]),
        .data_lo (cpu_data[SEL_W-1:0]),
        .layout_q(layout_q),
        .bank_q  (bank_q)
    );

    fmb_irq_timer #(
        .CNT_LIMIT(CNT_LIMIT)
    ) i_timer (
        .clk (clk),
        .rst_n(rst_n),
        .tick(cpu_tick),
        .ack (wr_kind == WR_ACK),
        .arm (wr_kind == WR_ARM),
        .irq (irq)
    );

    fmb_bank_map i_map (
        .layout_q    (layout_q),
        .bank_q      (bank_q),
        .prg_low     (prg_6000),
        .prg_slot    (prg_slot),
        .chr_bank    (chr_bank),
        .mirror_horiz(mirror_horiz)
    );

    assign prg_8000 = prg_slot[0];
    assign prg_a000 = prg_slot[1];
    assign prg_c000 = prg_slot[2];
    assign prg_e000 = prg_slot[3];

    // R6: a gated layout write shows its address byte on the character and mirroring outputs.
    assert_layout_from_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b110 && sub_sel == VID && !warm_rst)
        |=> (chr_bank == $past(cpu_addr[7:1]) && mirror_horiz == $past(cpu_addr[0])));

    // R6: an ungated layout write leaves the layout-driven outputs alone.
    assert_layout_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b110 && sub_sel != VID && !warm_rst)
        |=> ($stable(chr_bank) && $stable(mirror_horiz) && $stable(prg_8000)));

    // R5 and R7: in the fixed layout, a bank write shows up on the 0xC000 window.
    assert_bank_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b111)
        |=> (chr_bank[2] || prg_c000 == {1'b0, $past(cpu_data[2:0])}));

    // R11: the warm reset returns the layout-driven outputs to their cleared values.
    assert_warm_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (chr_bank == 7'd0 && !mirror_horiz && prg_8000 == 4'd4));

endmodule

// File: tb/test_fixed_map_banker.sv
// Bench for fixed_map_banker. A behavioural reference model advances on every
// rising edge, and every output is compared with it at each falling edge.
// Directed checks with literal expected values cover each requirement.
module test_fixed_map_banker;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_tick = 1'b0;
    logic [3:0]  sub_sel = 4'd1;
    logic [3:0]  prg_6000, prg_8000, prg_a000, prg_c000, prg_e000;
    logic [6:0]  chr_bank;
    logic        mirror_horiz;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;
    bit done    = 1'b0;

    // Reference model state.
    int m_layout = 0, m_bank = 0, m_en = 0, m_cnt = 0, m_irq = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fixed_map_banker i_fixed_map_banker (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .cpu_tick(cpu_tick), .sub_sel(sub_sel),
        .prg_6000(prg_6000), .prg_8000(prg_8000), .prg_a000(prg_a000),
        .prg_c000(prg_c000), .prg_e000(prg_e000), .chr_bank(chr_bank),
        .mirror_horiz(mirror_horiz), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected 8 KiB bank for window w (0 = 0x8000 ... 3 = 0xE000).
    function automatic int exp_win(input int w);
        if ((m_layout & 8) == 0) begin
            if (w == 0) return 4;
            if (w == 1) return 5;
            if (w == 2) return m_bank;
            return 7;
        end
        if ((m_layout & 16) != 0) return (2 | (m_layout >> 6)) * 4 + w;
        return (4 | (m_layout >> 5)) * 2 + (w % 2);
    endfunction

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        int nl, nb, ne, nc, ni;
        bit ack, arm;
        nl = m_layout; nb = m_bank; ne = m_en; nc = m_cnt; ni = m_irq;
        ack = 0; arm = 0;
        if (!rst_n) begin
            nl = 0; nb = 0; ne = 0; nc = 0; ni = 0;
        end else begin
            if (cpu_wr && cpu_addr >= 16'h8000) begin
                if (cpu_addr < 16'hA000) ack = 1;
                else if (cpu_addr < 16'hC000) arm = 1;
                else if (cpu_addr < 16'hE000) begin
                    if (sub_sel == 4'd1) nl = cpu_addr & 16'hFF;
                end else nb = cpu_data & 7;
            end
            if (ack) begin
                ne = 0; nc = 0; ni = 0;
            end else begin
                if (arm) ne = 1;
                if (m_en != 0 && cpu_tick) begin
                    if (m_cnt + 1 == LIMIT) begin nc = 0; ni = 1; ne = 0; end
                    else nc = m_cnt + 1;
                end
            end
            if (warm_rst) nl = 0;
        end
        m_layout = nl; m_bank = nb; m_en = ne; m_cnt = nc; m_irq = ni;
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            string ptag;
            ptag = ((m_layout & 8) == 0) ? "R7" : (((m_layout & 16) != 0) ? "R8" : "R9");
            chk("R12", "prg_6000", prg_6000, 6);
            chk(ptag, "prg_8000", prg_8000, exp_win(0));
            chk(ptag, "prg_a000", prg_a000, exp_win(1));
            chk(ptag, "prg_c000", prg_c000, exp_win(2));
            chk(ptag, "prg_e000", prg_e000, exp_win(3));
            chk("R10", "chr_bank", chr_bank, m_layout >> 1);
            chk("R10", "mirror_horiz", mirror_horiz, m_layout & 1);
            chk("R4", "irq", irq, m_irq);
        end
    end

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_tick = 1'b1;
            @(negedge clk);
        end
        cpu_tick = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "prg_8000", prg_8000, 4);
        chk("R1", "prg_a000", prg_a000, 5);
        chk("R1", "prg_c000", prg_c000, 0);
        chk("R1", "prg_e000", prg_e000, 7);
        chk("R1", "chr_bank", chr_bank, 0);
        chk("R1", "irq", irq, 0);

        // R5: data bits 7:3 are ignored
        cpu_write(16'hE123, 8'hFD);
        chk("R5", "prg_c000", prg_c000, 5);

        // R6: layout write with a non-matching variant has no effect
        sub_sel = 4'd0;
        cpu_write(16'hC0FF, 8'h00);
        chk("R6", "chr_bank gated", chr_bank, 0);
        chk("R6", "prg_8000 gated", prg_8000, 4);
        sub_sel = 4'd1;

        // R6/R8/R10: layout from the address, data ignored; 0x1B = 32 KiB block 2
        cpu_write(16'hC01B, 8'hFF);
        chk("R6", "chr_bank from addr", chr_bank, 13);
        chk("R10", "mirror_horiz", mirror_horiz, 1);
        chk("R8", "prg_8000", prg_8000, 8);
        chk("R8", "prg_e000", prg_e000, 11);

        // R9: 0xE8 = 16 KiB block 7 shown twice
        cpu_write(16'hDFE8, 8'h00);
        chk("R9", "prg_8000", prg_8000, 14);
        chk("R9", "prg_a000", prg_a000, 15);
        chk("R9", "prg_c000", prg_c000, 14);
        chk("R9", "prg_e000", prg_e000, 15);
        chk("R12", "prg_6000", prg_6000, 6);

        // R8: 0xD8 = 32 KiB block 3
        cpu_write(16'hC0D8, 8'h00);
        chk("R8", "prg_c000", prg_c000, 14);
        // R9: 0x28 = 16 KiB block 5
        cpu_write(16'hC028, 8'h00);
        chk("R9", "prg_e000", prg_e000, 11);

        // R13: writes below 0x8000 change nothing
        cpu_write(16'h6000, 8'h07);
        cpu_write(16'h7FFF, 8'h03);
        cpu_write(16'h5C1B, 8'h00);
        chk("R13", "chr_bank", chr_bank, 20);
        chk("R13", "prg_8000", prg_8000, 10);

        // R11: warm reset clears the layout only; timer keeps counting
        cpu_write(16'hA000, 8'h00);
        ticks(100);
        warm_rst = 1'b1;
        cpu_addr = 16'hC0FF; cpu_wr = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0; cpu_wr = 1'b0;
        chk("R11", "chr_bank", chr_bank, 0);
        chk("R11", "prg_c000", prg_c000, 5);
        ticks(LIMIT - 101);
        chk("R11", "irq before limit", irq, 0);
        ticks(1);
        chk("R11", "irq after kept count", irq, 1);

        // R2: acknowledge clears irq
        cpu_write(16'h8000, 8'h00);
        chk("R2", "irq cleared", irq, 0);

        // R3/R4: full run with continuous ticks
        cpu_write(16'hBFFF, 8'h00);
        ticks(LIMIT - 1);
        chk("R4", "irq one tick early", irq, 0);
        ticks(1);
        chk("R4", "irq at limit", irq, 1);
        ticks(LIMIT + 10);
        chk("R4", "irq held", irq, 1);
        cpu_tick = 1'b1;
        cpu_write(16'h9ABC, 8'h00);
        cpu_tick = 1'b0;
        chk("R2", "irq ack with tick", irq, 0);

        // R2: acknowledge mid-count disarms
        cpu_write(16'hA000, 8'h00);
        ticks(1000);
        cpu_write(16'h8001, 8'h00);
        ticks(LIMIT + 50);
        chk("R2", "no irq after disarm", irq, 0);

        // R3: re-arm counts from zero with a gapped tick pattern
        cpu_write(16'hA5A5, 8'h00);
        for (int i = 0; i < 3 * LIMIT; i++) begin
            cpu_tick = (i % 3) != 0;
            @(negedge clk);
        end
        cpu_tick = 1'b0;
        chk("R3", "irq after gapped run", irq, 1);

        // R1: power reset from a busy state
        cpu_write(16'h8000, 8'h00);
        cpu_write(16'hC0FF, 8'h00);
        cpu_write(16'hA000, 8'h00);
        ticks(20);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "prg_c000 after reset", prg_c000, 0);
        chk("R1", "chr_bank after reset", chr_bank, 0);
        ticks(LIMIT);
        chk("R1", "timer disarmed after reset", irq, 0);

        idle(4);
        finish_run();
    end

endmodule